// File: doc/BRIEF.md
# Multi-mode pixel readout writer

This block sits between a pixel front-end chip's 26-bit parallel word bus and an external SRAM. It turns the incoming stream into SRAM writes in one of four ways, chosen by a mode input. In the injection-only mode it stays silent. In the time-over-threshold mode it keeps a histogram with one counter for each (loop, column, row, ToT) bin. In the calibration mode it keeps one hit counter for each (loop, column, row) pixel. In the source-scan mode it stores the raw stream of hit and end-of-event words.

The two counting modes update SRAM by read-modify-write. The read is issued in the cycle the hit word arrives. The incremented value is written in the next cycle. A one-entry bypass lets back-to-back hits on the same counter be counted at the full word rate.

In source-scan mode the block counts end-of-event words. When a programmed number of them has arrived, the window is closed and a 32-bit trigger word is written one cycle after the last word of the window. The trigger word has a header bit of 1. Its payload is either an internal window counter or an externally supplied trigger number, and it can carry error and trigger-mode bits in its upper payload bits.

Top module: `pix_rdo_writer`

## Requirements
- R1: With `rdo_mode` = 0 (injection only), words on the bus cause no SRAM read and no SRAM write.
- R2: With `rdo_mode` = 1 (ToT histogram), a hit word (bit 25 = 0) raises `sram_re` in its own cycle. The read address is `{loop_idx, word[20:0]}`, so with default widths it is loop, then column = word[20:16], then row = word[15:8], then ToT = word[7:0]. In the next cycle the same address is written with the previous count plus one.
- R3: With `rdo_mode` = 2 (calibration), a hit word reads and then increments the counter at `{loop_idx, word[20:8]}`, zero-extended. The ToT bits do not affect the address.
- R4: Hits to the same counter in consecutive cycles are each counted. No increment is lost to the read-to-write latency.
- R5: A counter at its maximum value (all ones in CNT_W bits) is written back unchanged and never wraps.
- R6: With `rdo_mode` = 3 (source scan), every valid word is written one cycle after it arrives. The data is `{6'b0, word}`, and addresses run upward by one from 0 after reset, in arrival order.
- R7: After reset, and for idle cycles or end-of-event words (bit 25 = 1) in the counting modes, no SRAM read or write is made.
- R8: In source scan, the window closes on end-of-event word number `lv1_len`+1 (`lv1_len` 0..15 gives 1..16 words). A trigger word is then written at the next sequential address in the cycle after that word's own write, and at no other time. The bus must stay idle in that cycle.
- R9: For `trg_mode` 0, 1 or 3, the trigger number is an internal counter. It is 0 after reset and rises by one after every trigger word.
- R10: For `trg_mode` 2, the trigger number is `ext_trig_num`.
- R11: With `status_en` = 1, trigger word bits 30:25 carry `err_flags`, bits 24:23 carry `trg_mode`, and bits 22:0 carry the low 23 bits of the trigger number. Otherwise bits 30:0 carry the full 31-bit number.
- R12: Bit 31 of a trigger word is 1. Bit 31 of a stored raw data word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_valid | input | 1 | Bus word valid strobe |
| fe_word | input | 26 | Front-end word; bit 25 marks end-of-event |
| rdo_mode | input | 2 | 0 injection only, 1 ToT histogram, 2 calibration count, 3 source scan |
| trg_mode | input | 2 | Trigger number source selector |
| lv1_len | input | 4 | Window length minus one, in end-of-event words |
| loop_idx | input | LOOP_W | Scan loop number used in counter addresses |
| ext_trig_num | input | 31 | External trigger number |
| err_flags | input | 6 | Error bits for status insertion |
| status_en | input | 1 | Insert status bits into trigger words |
| sram_re | output | 1 | SRAM read strobe |
| sram_raddr | output | ADDR_W | SRAM read address |
| sram_rdata | input | 32 | SRAM read data, valid the cycle after `sram_re` |
| sram_we | output | 1 | SRAM write strobe |
| sram_waddr | output | ADDR_W | SRAM write address |
| sram_wdata | output | 32 | SRAM write data |

## Verification
The counting modes are driven with isolated hits and with one-cycle gaps between them. They are also driven with runs of two and three back-to-back hits on one bin. This separates a correct bypass from a stale read, which would drop increments. A counter preloaded one below its maximum shows whether the count sticks at the top or wraps. Calibration hits that differ only in ToT show whether that field is left out of the address. Source-scan windows of 1, 3 and 16 end-of-event words, with hits mixed in, show whether the window closes on the exact word. They also show whether the trigger word lands right after it, and each trigger-number source and the status layout is checked on its own window.

// File: rtl/pix_rdo_pkg.sv
package pix_rdo_pkg;
   localparam int WORD_W  = 26;
   localparam int SRAM_W  = 32;
   localparam int EOE_BIT = 25;

   typedef enum logic [1:0] {
      RM_FAKE = 2'd0,
      RM_TOT  = 2'd1,
      RM_CAL  = 2'd2,
      RM_SRC  = 2'd3
   } rdo_mode_e;

   typedef enum logic [1:0] {
      TM_FREE   = 2'd0,
      TM_SIMPLE = 2'd1,
      TM_DATA   = 2'd2,
      TM_RSVD   = 2'd3
   } trg_mode_e;
endpackage

// File: rtl/pix_rdo_addr.sv
module pix_rdo_addr
   import pix_rdo_pkg::*;
#(
   parameter int COL_W  = 5,
   parameter int ROW_W  = 8,
   parameter int TOT_W  = 8,
   parameter int LOOP_W = 2,
   parameter int ADDR_W = COL_W + ROW_W + TOT_W + LOOP_W
) (
   input  logic [WORD_W-1:0] word,
   input  logic [LOOP_W-1:0] loop_idx,
   input  logic [1:0]        mode,
   output logic              counting,
   output logic [ADDR_W-1:0] addr
);
   localparam int PIX_W = COL_W + ROW_W;

   logic [PIX_W-1:0] pix;
   logic [TOT_W-1:0] tot;

   always_comb begin
      pix      = word[TOT_W +: PIX_W];
      tot      = word[TOT_W-1:0];
      counting = !word[EOE_BIT] && (mode == RM_TOT || mode == RM_CAL);
      if (mode == RM_TOT) addr = ADDR_W'({loop_idx, pix, tot});
      else                addr = ADDR_W'({loop_idx, pix});
   end
endmodule

// File: rtl/pix_rdo_rmw.sv
module pix_rdo_rmw
   import pix_rdo_pkg::*;
#(
   parameter int ADDR_W   = 23,
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [SRAM_W-1:0] rd_data,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [SRAM_W-1:0] wr_data
);
   logic              s1_v, lw_v;
   logic [ADDR_W-1:0] s1_a, lw_a;
   logic [CNT_W-1:0]  lw_d, base, inc;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_v <= 1'b0;
         s1_a <= '0;
         lw_v <= 1'b0;
         lw_a <= '0;
         lw_d <= '0;
      end else begin
         s1_v <= rd_req;
         s1_a <= rd_addr;
         lw_v <= wr_valid;
         lw_a <= wr_addr;
         lw_d <= inc;
      end
   end

   // the write committed at the read edge is not seen by the SRAM read
   always_comb base = (lw_v && lw_a == s1_a) ? lw_d : rd_data[CNT_W-1:0];

   generate
      if (SATURATE) begin : g_sat
         always_comb inc = (&base) ? base : base + CNT_W'(1);

         AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
            wr_valid |-> (wr_data[CNT_W-1:0] != '0)); // R5
      end else begin : g_wrap
         always_comb inc = base + CNT_W'(1);
      end
   endgenerate

   always_comb begin
      wr_valid = s1_v;
      wr_addr  = s1_a;
      wr_data  = SRAM_W'(inc);
   end

   AST_FWD_CHAIN: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && $past(wr_valid) && wr_addr == $past(wr_addr)
       && $past(wr_data[CNT_W-1:0]) != '1)
      |-> wr_data[CNT_W-1:0] == $past(wr_data[CNT_W-1:0]) + CNT_W'(1)); // R4
endmodule

// File: rtl/pix_rdo_trig.sv
module pix_rdo_trig
   import pix_rdo_pkg::*;
#(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             raw_valid,
   input  logic             raw_eoe,
   input  logic [LEN_W-1:0] win_len,
   input  logic [1:0]       trg_mode,
   input  logic [30:0]      ext_num,
   input  logic [5:0]       err_flags,
   input  logic             status_en,
   output logic             trig_valid,
   output logic [31:0]      trig_data
);
   logic [LEN_W-1:0] eoe_seen;
   logic [30:0]      cnt, num, payload;

   always_comb begin
      num     = (trg_mode == TM_DATA) ? ext_num : cnt;
      payload = status_en ? {err_flags, trg_mode, num[22:0]} : num;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         eoe_seen   <= '0;
         cnt        <= '0;
         trig_valid <= 1'b0;
         trig_data  <= '0;
      end else begin
         trig_valid <= 1'b0;
         if (trig_valid) cnt <= cnt + 31'd1;
         if (raw_valid && raw_eoe) begin
            if (eoe_seen >= win_len) begin
               eoe_seen   <= '0;
               trig_valid <= 1'b1;
               trig_data  <= {1'b1, payload};
            end else begin
               eoe_seen <= eoe_seen + LEN_W'(1);
            end
         end
      end
   end

   AST_GAP_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
      trig_valid |-> !raw_valid); // R8

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      trig_valid |=> (cnt == $past(cnt) + 31'd1)); // R9
endmodule

// File: rtl/pix_rdo_writer.sv
module pix_rdo_writer
   import pix_rdo_pkg::*;
#(
   parameter int COL_W    = 5,
   parameter int ROW_W    = 8,
   parameter int TOT_W    = 8,
   parameter int LOOP_W   = 2,
   parameter int CNT_W    = 32,
   parameter int ADDR_W   = COL_W + ROW_W + TOT_W + LOOP_W,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fe_valid,
   input  logic [WORD_W-1:0] fe_word,
   input  logic [1:0]        rdo_mode,
   input  logic [1:0]        trg_mode,
   input  logic [3:0]        lv1_len,
   input  logic [LOOP_W-1:0] loop_idx,
   input  logic [30:0]       ext_trig_num,
   input  logic [5:0]        err_flags,
   input  logic              status_en,
   output logic              sram_re,
   output logic [ADDR_W-1:0] sram_raddr,
   input  logic [SRAM_W-1:0] sram_rdata,
   output logic              sram_we,
   output logic [ADDR_W-1:0] sram_waddr,
   output logic [SRAM_W-1:0] sram_wdata
);
   localparam int FIELD_W = COL_W + ROW_W + TOT_W;
   localparam int PAD_W   = SRAM_W - WORD_W;

   generate
      if (FIELD_W > WORD_W - 1) begin : g_bad_fields
         $error("pix_rdo_writer: pixel fields exceed the word");
      end
      if (CNT_W < 2 || CNT_W > SRAM_W) begin : g_bad_cnt
         $error("pix_rdo_writer: counter width out of range");
      end
      if (ADDR_W < FIELD_W + LOOP_W) begin : g_bad_addr
         $error("pix_rdo_writer: address too narrow");
      end
   endgenerate

   logic              counting;
   logic [ADDR_W-1:0] cnt_addr;
   logic              rmw_wv;
   logic [ADDR_W-1:0] rmw_wa;
   logic [SRAM_W-1:0] rmw_wd;
   logic              src_v;
   logic [WORD_W-1:0] src_word;
   logic              trig_v;
   logic [31:0]       trig_d;
   logic [ADDR_W-1:0] ptr;

   pix_rdo_addr #(
      .COL_W(COL_W), .ROW_W(ROW_W), .TOT_W(TOT_W),
      .LOOP_W(LOOP_W), .ADDR_W(ADDR_W)
   ) u_addr (
      .word(fe_word), .loop_idx(loop_idx), .mode(rdo_mode),
      .counting(counting), .addr(cnt_addr)
   );

   always_comb begin
      sram_re    = fe_valid && counting;
      sram_raddr = cnt_addr;
   end

   pix_rdo_rmw #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SATURATE(SATURATE)
   ) u_rmw (
      .clk(clk), .rst(rst),
      .rd_req(sram_re), .rd_addr(sram_raddr), .rd_data(sram_rdata),
      .wr_valid(rmw_wv), .wr_addr(rmw_wa), .wr_data(rmw_wd)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         src_v    <= 1'b0;
         src_word <= '0;
         ptr      <= '0;
      end else begin
         src_v    <= fe_valid && rdo_mode == RM_SRC;
         src_word <= fe_word;
         if (src_v || trig_v) ptr <= ptr + ADDR_W'(1);
      end
   end

   pix_rdo_trig #(.LEN_W(4)) u_trig (
      .clk(clk), .rst(rst),
      .raw_valid(src_v), .raw_eoe(src_word[EOE_BIT]),
      .win_len(lv1_len), .trg_mode(trg_mode), .ext_num(ext_trig_num),
      .err_flags(err_flags), .status_en(status_en),
      .trig_valid(trig_v), .trig_data(trig_d)
   );

   always_comb begin
      sram_we = rmw_wv || src_v || trig_v;
      if (rmw_wv) begin
         sram_waddr = rmw_wa;
         sram_wdata = rmw_wd;
      end else begin
         sram_waddr = ptr;
         sram_wdata = src_v ? {{PAD_W{1'b0}}, src_word} : trig_d;
      end
   end

   AST_FAKE_SILENT: assert property (@(posedge clk) disable iff (rst)
      ($past(rdo_mode) == RM_FAKE) |-> (!sram_we || trig_v)); // R1

   AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rmw_wv, src_v, trig_v})); // R8

   AST_HDR_MARK: assert property (@(posedge clk) disable iff (rst)
      (src_v || trig_v) |-> (sram_wdata[31] == trig_v)); // R12
endmodule

// File: tb/pix_rdo_writer_test.sv
module pix_rdo_writer_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fe_valid = 1'b0;
   logic [25:0] fe_word = '0;
   logic [1:0]  rdo_mode = 2'd0;
   logic [1:0]  trg_mode = 2'd0;
   logic [3:0]  lv1_len = 4'd0;
   logic [1:0]  loop_idx = 2'd1;
   logic [30:0] ext_trig_num = '0;
   logic [5:0]  err_flags = '0;
   logic        status_en = 1'b0;
   logic        sram_re, sram_we;
   logic [22:0] sram_raddr, sram_waddr;
   logic [31:0] sram_rdata, sram_wdata;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   bit [31:0] bmem [int];
   bit [31:0] rmem [int];
   logic [31:0] rdq = '0;

   int ptr_ref = 0;
   int eoe_n   = 0;
   bit pend    = 1'b0;
   logic [30:0] tcnt = '0;

   always #5 clk = ~clk;

   pix_rdo_writer uut (
      .clk(clk), .rst(rst), .fe_valid(fe_valid), .fe_word(fe_word),
      .rdo_mode(rdo_mode), .trg_mode(trg_mode), .lv1_len(lv1_len),
      .loop_idx(loop_idx), .ext_trig_num(ext_trig_num), .err_flags(err_flags),
      .status_en(status_en), .sram_re(sram_re), .sram_raddr(sram_raddr),
      .sram_rdata(sram_rdata), .sram_we(sram_we), .sram_waddr(sram_waddr),
      .sram_wdata(sram_wdata)
   );

   assign sram_rdata = rdq;

   always @(posedge clk) begin
      if (sram_re) rdq <= bmem[int'(sram_raddr)];
      if (sram_we) bmem[int'(sram_waddr)] = sram_wdata;
   end

   function automatic logic [25:0] hw(int col, int row, int tot);
      return {5'b0, 5'(col), 8'(row), 8'(tot)};
   endfunction

   function automatic logic [25:0] ew(int bc);
      return {1'b1, 17'b0, 8'(bc)};
   endfunction

   function automatic logic [31:0] trig_word();
      logic [30:0] num;
      logic [30:0] pl;
      num = (trg_mode == 2'd2) ? ext_trig_num : tcnt;
      pl  = status_en ? {err_flags, trg_mode, num[22:0]} : num;
      return {1'b1, pl};
   endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(bit v, logic [25:0] w, string tag);
      bit          exp_re, exp_we, is_hit, cnt_mode;
      int          a;
      logic [31:0] ed, old;
      fe_valid = v;
      fe_word  = w;
      is_hit   = !w[25];
      cnt_mode = (rdo_mode == 2'd1) || (rdo_mode == 2'd2);
      a = (rdo_mode == 2'd1) ? ((int'(loop_idx) << 21) | int'(w[20:0]))
                             : ((int'(loop_idx) << 13) | int'(w[20:8]));
      exp_re = v && is_hit && cnt_mode;
      #1;
      chk(tag, "read strobe", 64'(sram_re), 64'(exp_re));
      if (exp_re) chk(tag, "read addr", 64'(sram_raddr), 64'(a));
      exp_we = 1'b1;
      ed = '0;
      if (v && rdo_mode == 2'd3) begin
         a  = ptr_ref;
         ed = {6'b0, w};
         ptr_ref++;
      end else if (exp_re) begin
         old = rmem.exists(a) ? rmem[a] : 32'd0;
         ed  = (old == 32'hFFFF_FFFF) ? old : old + 32'd1;
         rmem[a] = ed;
      end else if (pend) begin
         a  = ptr_ref;
         ed = trig_word();
         ptr_ref++;
         tcnt = tcnt + 31'd1;
         pend = 1'b0;
      end else begin
         exp_we = 1'b0;
      end
      if (v && rdo_mode == 2'd3 && w[25]) begin
         eoe_n++;
         if (eoe_n == int'(lv1_len) + 1) begin
            eoe_n = 0;
            pend  = 1'b1;
         end
      end
      @(posedge clk);
      #1;
      chk(tag, "write strobe", 64'(sram_we), 64'(exp_we));
      if (exp_we) begin
         chk(tag, "write addr", 64'(sram_waddr), 64'(a));
         chk(tag, "write data", 64'(sram_wdata), 64'(ed));
      end
   endtask

   task automatic gap_trig(string tag);
      // trigger word after a closing end-of-event word; header per R12
      cyc(1'b0, '0, tag);
      chk("R12", "trigger header", 64'(sram_wdata[31]), 64'd1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      chk("R7", "reset write strobe", 64'(sram_we), 64'd0);
      chk("R7", "reset read strobe", 64'(sram_re), 64'd0);

      // R1: injection-only mode
      rdo_mode = 2'd0;
      cyc(1'b1, hw(3, 10, 5), "R1");
      cyc(1'b1, ew(1), "R1");
      cyc(1'b1, hw(7, 20, 9), "R1");
      cyc(1'b0, '0, "R1");

      // R2 / R4 / R7: ToT histogram
      rdo_mode = 2'd1;
      cyc(1'b1, hw(3, 10, 5), "R2");
      cyc(1'b1, hw(3, 10, 6), "R2");
      cyc(1'b1, hw(3, 10, 5), "R4");
      cyc(1'b1, hw(3, 10, 5), "R4");
      cyc(1'b1, hw(3, 10, 5), "R4");
      cyc(1'b1, ew(2), "R7");
      cyc(1'b0, '0, "R7");
      cyc(1'b1, hw(31, 255, 255), "R2");
      cyc(1'b0, '0, "R2");

      // R5: saturation at the counter maximum
      bmem[(1 << 21) | int'(hw(1, 2, 3))] = 32'hFFFF_FFFE;
      rmem[(1 << 21) | int'(hw(1, 2, 3))] = 32'hFFFF_FFFE;
      cyc(1'b1, hw(1, 2, 3), "R5");
      cyc(1'b1, hw(1, 2, 3), "R5");
      cyc(1'b1, hw(1, 2, 3), "R5");
      cyc(1'b0, '0, "R5");

      // R3: calibration hit count
      rdo_mode = 2'd2;
      loop_idx = 2'd2;
      cyc(1'b1, hw(4, 7, 1), "R3");
      cyc(1'b1, hw(4, 7, 200), "R3");
      cyc(1'b0, '0, "R3");
      cyc(1'b1, hw(5, 7, 1), "R3");
      cyc(1'b1, ew(3), "R7");
      cyc(1'b1, hw(4, 7, 77), "R3");
      cyc(1'b0, '0, "R3");

      // R6 / R8 / R9: source scan, three end-of-event words per window
      rdo_mode = 2'd3;
      lv1_len  = 4'd2;
      trg_mode = 2'd0;
      cyc(1'b1, hw(2, 3, 4), "R6");
      cyc(1'b1, ew(10), "R6");
      cyc(1'b1, hw(2, 4, 4), "R6");
      cyc(1'b1, ew(11), "R8");
      cyc(1'b1, ew(12), "R8");
      gap_trig("R9");
      cyc(1'b1, ew(13), "R8");
      cyc(1'b1, hw(9, 9, 9), "R6");
      cyc(1'b1, ew(14), "R8");
      cyc(1'b1, ew(15), "R8");
      gap_trig("R9");

      // R9: simple-handshake mode still counts
      trg_mode = 2'd1;
      lv1_len  = 4'd0;
      cyc(1'b1, ew(20), "R8");
      gap_trig("R9");

      // R10: external trigger number
      trg_mode     = 2'd2;
      ext_trig_num = 31'h5A5A_1234;
      cyc(1'b1, ew(21), "R8");
      gap_trig("R10");

      // R11: status insertion with internal number
      status_en = 1'b1;
      err_flags = 6'b101101;
      trg_mode  = 2'd1;
      cyc(1'b1, ew(22), "R8");
      gap_trig("R11");

      // R8: longest window, sixteen end-of-event words
      status_en = 1'b0;
      trg_mode  = 2'd3;
      lv1_len   = 4'd15;
      for (int i = 0; i < 15; i++) begin
         cyc(1'b1, ew(30 + i), "R8");
         if (i == 7) cyc(1'b1, hw(6, 6, 6), "R6");
      end
      cyc(1'b1, ew(45), "R8");
      gap_trig("R8");

      // R11: status insertion with external number
      status_en    = 1'b1;
      trg_mode     = 2'd2;
      err_flags    = 6'b010011;
      ext_trig_num = 31'h7FFF_FFFF;
      lv1_len      = 4'd1;
      cyc(1'b1, ew(50), "R8");
      cyc(1'b1, ew(51), "R8");
      gap_trig("R11");
      chk("R12", "data header", 64'(bmem[0][31]), 64'd0);
      cyc(1'b0, '0, "R7");
      cyc(1'b0, '0, "R7");

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule